// File: doc/BRIEF.md
# Three-Tier 16-Bit Instruction Decoder

This block takes one 16-bit instruction word and classifies it. It outputs a compact operation code, the register indices and the immediate or shift fields that the operation uses. It also raises a set of class flags for memory access, port I/O, control transfer, special exception-register access and unrecognised encodings. The block only classifies and extracts. The register file, the ALU, memory and the exception machinery all sit downstream and consume these outputs.

Every word has four nibbles: destination (bits 15..12), source A (11..8), source B (7..4) and opcode (3..0). An opcode nibble of all ones is an escape code. It moves decoding to the single-source tier, where the B nibble becomes the sub-opcode. If the B nibble is all ones as well, decoding moves one tier deeper to the single-register tier, where the A nibble becomes the sub-opcode.

The `REG_OUT` parameter chooses the output timing. When it is 0 the outputs follow the input combinationally. When it is nonzero the outputs are taken from a reset-cleared register stage that adds one cycle of latency.

Top module: `nibble_insn_decoder`

## Requirements
- R1: `rd_o` always equals bits 15..12. `ra_o` equals bits 11..8 in tiers 0 and 1 and is 0 in tier 2. `rb_o` equals bits 7..4 in tier 0 and is 0 otherwise.
- R2: When bits 3..0 are not 4'hF, `tier_o` is 0 and `op_o` is {2'b00, bits 3..0}. Codes 0x00 to 0x0E are, in order: load-immediate-low, load-immediate-high, load byte, load word, store byte, store word, add, add-with-carry, and, or, xor, shift-left, logical shift-right, arithmetic shift-right, conditional branch.
- R3: When bits 3..0 are 4'hF and bits 7..4 are not 4'hF, `tier_o` is 1 and `op_o` is {2'b01, bits 7..4}. Codes 0x10 to 0x1E are: move, negate, not, compare, call, swap, in, out, in-imm, out-imm, add-imm, and-imm, or-imm, shift-imm, compare-imm.
- R4: When bits 7..0 are 8'hFF and bits 11..8 are at most 4'hA, `tier_o` is 2 and `op_o` is {2'b10, bits 11..8}. Codes 0x20 to 0x2A are: return-from-interrupt, trap, trap-imm, then get/set pairs for exception PC, exception status, exception number and exception user register.
- R5: When bits 7..0 are 8'hFF and bits 11..8 are 4'hB or above, the outputs are `tier_o` = 2, `op_o` = 0x3F and `ill_o` = 1, and every other flag is 0. In all other cases `ill_o` is 0.
- R6: `imm_o` depends on the tier. In tier 0 it is bits 11..4, with A as the upper nibble and B as the lower. In tier 1 it is bits 11..8 zero-extended. In tier 2 it is 0.
- R7: For op 0x1D only, `shamt_o` is bits 10..8 and `shr_o` is bit 11 (1 means shift right). For every other op both outputs are 0.
- R8: `mem_o` is 1 exactly for ops 0x02 to 0x05.
- R9: `io_o` is 1 exactly for ops 0x16 to 0x19.
- R10: `br_o` is 1 for ops 0x0E, 0x14 and 0x20. It is also 1 when `rd_o` = 14 and the op writes its destination. The ops that write their destination are 0x00 to 0x03, 0x06 to 0x0D, 0x10 to 0x12, 0x14 to 0x16, 0x18, 0x1A to 0x1D, 0x23, 0x25, 0x27 and 0x29.
- R11: `exc_o` is 1 exactly for ops 0x23 to 0x2A.
- R12: With `REG_OUT` = 0 the outputs reflect the current `instr_i`. With `REG_OUT` nonzero they reflect the `instr_i` sampled at the previous rising edge of `clk`.
- R13: With `REG_OUT` nonzero, all outputs are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| instr_i | input | 16 | Instruction word |
| op_o | output | 6 | Operation code, {tier, sub-code} or 0x3F |
| tier_o | output | 2 | Format tier 0, 1 or 2 |
| rd_o | output | 4 | Destination register index |
| ra_o | output | 4 | Source A register index |
| rb_o | output | 4 | Source B register index |
| imm_o | output | 8 | Immediate value |
| shamt_o | output | 3 | Shift-immediate amount |
| shr_o | output | 1 | Shift-immediate direction, 1 = right |
| mem_o | output | 1 | Memory access |
| io_o | output | 1 | Port I/O access |
| br_o | output | 1 | Control transfer |
| exc_o | output | 1 | Exception special-register access |
| ill_o | output | 1 | Illegal encoding |

## Verification
The bench builds two instances side by side. One uses `REG_OUT` = 1, which makes the reset state and the one-cycle latency observable. The other uses `REG_OUT` = 0, which exposes the purely combinational path. Both instances receive all 65536 instruction words in sequence, so every escape boundary is exercised. This includes every illegal single-register code and every destination-14 combination, compared against the model on every cycle.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int WORD_W = 16;
  localparam int NIB_W  = 4;
  localparam int OP_W   = 6;
  localparam int IMM_W  = 8;
  localparam int SH_W   = 3;

  typedef enum logic [1:0] {
    TIER_PRI  = 2'd0,
    TIER_SSRC = 2'd1,
    TIER_SREG = 2'd2
  } tier_e;

  localparam logic [NIB_W-1:0] ESC_NIB     = '1;
  localparam logic [NIB_W-1:0] SREG_LAST   = 4'hA;
  localparam logic [OP_W-1:0]  OP_LD8      = 6'h02;
  localparam logic [OP_W-1:0]  OP_STR16    = 6'h05;
  localparam logic [OP_W-1:0]  OP_BCC      = 6'h0E;
  localparam logic [OP_W-1:0]  OP_CALL     = 6'h14;
  localparam logic [OP_W-1:0]  OP_IN       = 6'h16;
  localparam logic [OP_W-1:0]  OP_OUTI     = 6'h19;
  localparam logic [OP_W-1:0]  OP_SHI      = 6'h1D;
  localparam logic [OP_W-1:0]  OP_RETI     = 6'h20;
  localparam logic [OP_W-1:0]  OP_GETEPC   = 6'h23;
  localparam logic [OP_W-1:0]  OP_SETUER   = 6'h2A;
  localparam logic [OP_W-1:0]  OP_ILLEGAL  = 6'h3F;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    tier_e            tier;
    logic [NIB_W-1:0] rd;
    logic [NIB_W-1:0] ra;
    logic [NIB_W-1:0] rb;
    logic [IMM_W-1:0] imm;
    logic [SH_W-1:0]  shamt;
    logic             shr;
    logic             mem;
    logic             io;
    logic             br;
    logic             exc;
    logic             ill;
  } dec_s;

  function automatic logic in_span(logic [OP_W-1:0] op,
                                   logic [OP_W-1:0] lo,
                                   logic [OP_W-1:0] hi);
    return (op >= lo) && (op <= hi);
  endfunction

  // Ops whose destination field names a register that gets written.
  function automatic logic writes_dest(logic [OP_W-1:0] op);
    case (op)
      6'h00, 6'h01, 6'h02, 6'h03,
      6'h06, 6'h07, 6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D,
      6'h10, 6'h11, 6'h12, 6'h14, 6'h15, 6'h16, 6'h18,
      6'h1A, 6'h1B, 6'h1C, 6'h1D,
      6'h23, 6'h25, 6'h27, 6'h29: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/idec_primary.sv
module idec_primary
  import idec_pkg::*;
(
  input  logic [11:0]      fld_i,   // A, B, opcode nibbles
  output logic [OP_W-1:0]  op_o,
  output logic [NIB_W-1:0] ra_o,
  output logic [NIB_W-1:0] rb_o,
  output logic [IMM_W-1:0] imm_o,
  output logic             mem_o
);
  assign op_o  = {2'b00, fld_i[3:0]};
  assign ra_o  = fld_i[11:8];
  assign rb_o  = fld_i[7:4];
  assign imm_o = fld_i[11:4];
  assign mem_o = in_span(op_o, OP_LD8, OP_STR16);
endmodule

// File: rtl/idec_single_src.sv
module idec_single_src
  import idec_pkg::*;
(
  input  logic [7:0]       fld_i,   // A nibble, sub-opcode nibble
  output logic [OP_W-1:0]  op_o,
  output logic [NIB_W-1:0] ra_o,
  output logic [IMM_W-1:0] imm_o,
  output logic [SH_W-1:0]  shamt_o,
  output logic             shr_o,
  output logic             io_o
);
  logic [NIB_W-1:0] a_nib;
  logic             is_shi;

  assign a_nib   = fld_i[7:4];
  assign op_o    = {2'b01, fld_i[3:0]};
  assign ra_o    = a_nib;
  assign imm_o   = {{(IMM_W-NIB_W){1'b0}}, a_nib};
  assign is_shi  = (op_o == OP_SHI);
  assign shamt_o = is_shi ? a_nib[SH_W-1:0] : '0;
  assign shr_o   = is_shi & a_nib[NIB_W-1];
  assign io_o    = in_span(op_o, OP_IN, OP_OUTI);
endmodule

// File: rtl/idec_single_reg.sv
module idec_single_reg
  import idec_pkg::*;
(
  input  logic [NIB_W-1:0] sub_i,
  output logic [OP_W-1:0]  op_o,
  output logic             exc_o,
  output logic             ill_o
);
  logic legal;

  assign legal = (sub_i <= SREG_LAST);
  assign op_o  = legal ? {2'b10, sub_i} : OP_ILLEGAL;
  assign exc_o = legal & in_span(op_o, OP_GETEPC, OP_SETUER);
  assign ill_o = ~legal;
endmodule

// File: rtl/idec_out_stage.sv
module idec_out_stage
  import idec_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  dec_s d_i,
  output dec_s q_o
);
  generate
    if (REG_OUT != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
      end
    end else begin : g_comb
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/nibble_insn_decoder.sv
module nibble_insn_decoder
  import idec_pkg::*;
#(
  parameter int REG_OUT = 1,
  parameter int PC_REG  = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] instr_i,
  output logic [5:0]  op_o,
  output logic [1:0]  tier_o,
  output logic [3:0]  rd_o,
  output logic [3:0]  ra_o,
  output logic [3:0]  rb_o,
  output logic [7:0]  imm_o,
  output logic [2:0]  shamt_o,
  output logic        shr_o,
  output logic        mem_o,
  output logic        io_o,
  output logic        br_o,
  output logic        exc_o,
  output logic        ill_o
);
  localparam logic [NIB_W-1:0] PC_IDX = NIB_W'(PC_REG);

  // tier 0 results
  logic [OP_W-1:0]  p_op;
  logic [NIB_W-1:0] p_ra, p_rb;
  logic [IMM_W-1:0] p_imm;
  logic             p_mem;
  // tier 1 results
  logic [OP_W-1:0]  s_op;
  logic [NIB_W-1:0] s_ra;
  logic [IMM_W-1:0] s_imm;
  logic [SH_W-1:0]  s_shamt;
  logic             s_shr, s_io;
  // tier 2 results
  logic [OP_W-1:0]  r_op;
  logic             r_exc, r_ill;

  // named internal events for the checker
  logic             esc1, esc2;
  tier_e            nxt_tier;
  logic [OP_W-1:0]  nxt_op;
  dec_s             nxt, cur;

  idec_primary u_pri (
    .fld_i(instr_i[11:0]), .op_o(p_op), .ra_o(p_ra), .rb_o(p_rb),
    .imm_o(p_imm), .mem_o(p_mem)
  );

  idec_single_src u_ssrc (
    .fld_i(instr_i[11:4]), .op_o(s_op), .ra_o(s_ra), .imm_o(s_imm),
    .shamt_o(s_shamt), .shr_o(s_shr), .io_o(s_io)
  );

  idec_single_reg u_sreg (
    .sub_i(instr_i[11:8]), .op_o(r_op), .exc_o(r_exc), .ill_o(r_ill)
  );

  assign esc1     = (instr_i[3:0] == ESC_NIB);
  assign esc2     = esc1 && (instr_i[7:4] == ESC_NIB);
  assign nxt_tier = esc2 ? TIER_SREG : (esc1 ? TIER_SSRC : TIER_PRI);

  always_comb begin
    nxt    = '0;
    nxt.rd = instr_i[15:12];
    nxt.tier = nxt_tier;
    unique case (nxt_tier)
      TIER_PRI: begin
        nxt.op  = p_op;
        nxt.ra  = p_ra;
        nxt.rb  = p_rb;
        nxt.imm = p_imm;
        nxt.mem = p_mem;
      end
      TIER_SSRC: begin
        nxt.op    = s_op;
        nxt.ra    = s_ra;
        nxt.imm   = s_imm;
        nxt.shamt = s_shamt;
        nxt.shr   = s_shr;
        nxt.io    = s_io;
      end
      default: begin
        nxt.op  = r_op;
        nxt.exc = r_exc;
        nxt.ill = r_ill;
      end
    endcase
    nxt.br = (nxt.op == OP_BCC) || (nxt.op == OP_CALL) ||
             (nxt.op == OP_RETI) ||
             ((nxt.rd == PC_IDX) && writes_dest(nxt.op));
  end

  assign nxt_op = nxt.op;

  idec_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .d_i(nxt), .q_o(cur)
  );

  assign op_o    = cur.op;
  assign tier_o  = cur.tier;
  assign rd_o    = cur.rd;
  assign ra_o    = cur.ra;
  assign rb_o    = cur.rb;
  assign imm_o   = cur.imm;
  assign shamt_o = cur.shamt;
  assign shr_o   = cur.shr;
  assign mem_o   = cur.mem;
  assign io_o    = cur.io;
  assign br_o    = cur.br;
  assign exc_o   = cur.exc;
  assign ill_o   = cur.ill;
endmodule

// File: rtl/idec_checker.sv
module idec_checker #(
  parameter int REG_OUT = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] nxt_op,
  input logic [5:0] op_o,
  input logic [1:0] tier_o,
  input logic [2:0] shamt_o,
  input logic       shr_o,
  input logic       mem_o,
  input logic       io_o,
  input logic       br_o,
  input logic       exc_o,
  input logic       ill_o
);
  // R12: registered outputs carry the decode of the previous edge
  assert_reg_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((REG_OUT != 0) && $past(rst_n)) |-> (op_o == $past(nxt_op)));

  assert_illegal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ill_o |-> (tier_o == 2'd2 && op_o == 6'h3F && !br_o));

  assert_class_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_o, io_o, exc_o, ill_o}));

  assert_mem_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_o |-> (op_o >= 6'h02 && op_o <= 6'h05));

  assert_io_tier_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_o |-> (tier_o == 2'd1));

  assert_exc_tier_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> (tier_o == 2'd2));

  assert_shift_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shr_o || shamt_o != 3'd0) |-> (op_o == 6'h1D));
endmodule

bind nibble_insn_decoder idec_checker #(.REG_OUT(REG_OUT)) u_idec_chk (
  .clk(clk), .rst_n(rst_n), .nxt_op(nxt_op), .op_o(op_o), .tier_o(tier_o),
  .shamt_o(shamt_o), .shr_o(shr_o), .mem_o(mem_o), .io_o(io_o),
  .br_o(br_o), .exc_o(exc_o), .ill_o(ill_o)
);

// File: tb/test_nibble_insn_decoder.sv
module test_nibble_insn_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  logic [5:0] r_op, c_op;
  logic [1:0] r_tier, c_tier;
  logic [3:0] r_rd, r_ra, r_rb, c_rd, c_ra, c_rb;
  logic [7:0] r_imm, c_imm;
  logic [2:0] r_sh, c_sh;
  logic       r_shr, r_mem, r_io, r_br, r_exc, r_ill;
  logic       c_shr, c_mem, c_io, c_br, c_exc, c_ill;

  nibble_insn_decoder #(.REG_OUT(1)) i_nibble_insn_decoder (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .op_o(r_op), .tier_o(r_tier),
    .rd_o(r_rd), .ra_o(r_ra), .rb_o(r_rb), .imm_o(r_imm), .shamt_o(r_sh),
    .shr_o(r_shr), .mem_o(r_mem), .io_o(r_io), .br_o(r_br), .exc_o(r_exc),
    .ill_o(r_ill)
  );

  nibble_insn_decoder #(.REG_OUT(0)) i_nibble_insn_decoder_comb (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .op_o(c_op), .tier_o(c_tier),
    .rd_o(c_rd), .ra_o(c_ra), .rb_o(c_rb), .imm_o(c_imm), .shamt_o(c_sh),
    .shr_o(c_shr), .mem_o(c_mem), .io_o(c_io), .br_o(c_br), .exc_o(c_exc),
    .ill_o(c_ill)
  );

  task automatic chk(string tag, string who, int w, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s word %04h: actual %0h expected %0h", tag, who, w, act, exp);
    end
  endtask

  function automatic int dest_written(int op);
    if (op <= 3 || (op >= 6 && op <= 13)) return 1;
    if (op == 16 || op == 17 || op == 18 || op == 20 || op == 21 || op == 22 ||
        op == 24 || (op >= 26 && op <= 29)) return 1;
    if (op >= 35 && op <= 41 && (op % 2) == 1) return 1;
    return 0;
  endfunction

  // Behavioural reference of the requirements.
  task automatic model(input int w, output int op, output int tier, output int rd,
                       output int ra, output int rb, output int imm, output int sh,
                       output int shr, output int mem, output int io, output int br,
                       output int exc, output int ill);
    int o = w % 16;
    int b = (w / 16) % 16;
    int a = (w / 256) % 16;
    int d = w / 4096;
    op = 0; tier = 0; ra = 0; rb = 0; imm = 0; sh = 0; shr = 0;
    mem = 0; io = 0; exc = 0; ill = 0;
    rd = d;
    if (o != 15) begin
      op = o; ra = a; rb = b; imm = a * 16 + b;
      mem = (o >= 2 && o <= 5) ? 1 : 0;
    end else if (b != 15) begin
      tier = 1; op = 16 + b; ra = a; imm = a;
      if (b == 13) begin sh = a % 8; shr = a / 8; end
      io = (b >= 6 && b <= 9) ? 1 : 0;
    end else begin
      tier = 2;
      if (a > 10) begin op = 63; ill = 1; end
      else begin op = 32 + a; exc = (a >= 3) ? 1 : 0; end
    end
    br = (op == 14 || op == 20 || op == 32 || (d == 14 && dest_written(op) != 0)) ? 1 : 0;
  endtask

  task automatic check_set(string who, int w,
      logic [5:0] op, logic [1:0] tier, logic [3:0] rd, logic [3:0] ra, logic [3:0] rb,
      logic [7:0] imm, logic [2:0] sh, logic shr, logic mem, logic io, logic br,
      logic exc, logic ill);
    int e_op, e_tier, e_rd, e_ra, e_rb, e_imm, e_sh, e_shr, e_mem, e_io, e_br, e_exc, e_ill;
    string ttag;
    model(w, e_op, e_tier, e_rd, e_ra, e_rb, e_imm, e_sh, e_shr, e_mem, e_io, e_br, e_exc, e_ill);
    ttag = (e_tier == 0) ? "R2" : (e_tier == 1) ? "R3" : (e_ill != 0) ? "R5" : "R4";
    chk(ttag, who, w, int'(op), e_op);
    chk(ttag, who, w, int'(tier), e_tier);
    chk("R1", who, w, int'({rd, ra, rb}), e_rd * 256 + e_ra * 16 + e_rb);
    chk("R6", who, w, int'(imm), e_imm);
    chk("R7", who, w, int'({shr, sh}), e_shr * 8 + e_sh);
    chk("R8", who, w, int'(mem), e_mem);
    chk("R9", who, w, int'(io), e_io);
    chk("R10", who, w, int'(br), e_br);
    chk("R11", who, w, int'(exc), e_exc);
    chk("R5", who, w, int'(ill), e_ill);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13: registered outputs cleared during reset
    chk("R13", "reg", int'(instr), int'({r_op, r_tier, r_rd, r_ra, r_rb}), 0);
    chk("R13", "reg", int'(instr), int'({r_imm, r_sh, r_shr, r_mem, r_io, r_br, r_exc, r_ill}), 0);
    rst_n = 1'b1;
    instr = 16'h0000;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      // R12: comb instance follows instr now; registered one shows last edge's word
      check_set("R12 comb", int'(instr), c_op, c_tier, c_rd, c_ra, c_rb, c_imm, c_sh,
                c_shr, c_mem, c_io, c_br, c_exc, c_ill);
      check_set("R12 reg", int'(instr), r_op, r_tier, r_rd, r_ra, r_rb, r_imm, r_sh,
                r_shr, r_mem, r_io, r_br, r_exc, r_ill);
      instr = 16'(i + 1);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20ns * 190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule